// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block gathers interrupt requests from asynchronous external pins and from synchronous peripheral event strobes (timer overflow, compare match and similar). Each request is caught in a sticky pending flag. The flag is then qualified by a per-source enable bit and by a global enable. A fixed-priority picker selects the eligible source with the lowest vector number. The controller hands that source's vector number and its word address to a processor front end as a registered, held offer.

The processor takes an offer by pulsing an acknowledge. This clears the serviced flag and drops the global enable, so that handlers cannot nest. A return-from-interrupt pulse sets the global enable again, and the next eligible source is then offered. Vector 0 is the reset vector. It is offered straight out of reset ahead of everything else, and acknowledging it opens the global enable for the first time. External pins pass through a synchroniser and an edge detector, so one-cycle pulses are never lost. Peripheral strobes latch on the edge at which they are sampled high.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Out of reset the block offers vector 0 (`vec_valid_o`=1, `vec_addr_o`=0) and keeps offering it, whatever else is pending, until it is acknowledged. Acknowledging vector 0 sets the global enable. One cycle later, any eligible pending source is offered.
- R2: Vector numbers and addresses work as follows. External pin k is vector k+1. Peripheral line j is vector N_EXT+1+j. The offered address is vector number × 2. With the defaults (2 pins, 4 peripherals), pin 0→2, pin 1→4, peripheral 0→6, peripheral 1→8, peripheral 2→10 and peripheral 3→12.
- R3: Enable bit i of `irq_en_i` governs vector i+1 (bits 0..1 are the pins, bits 2..5 are peripherals 0..3). A source whose enable bit is 0 is never offered, but its pending flag survives. Setting the bit later gets it offered on the next clock edge.
- R4: When several enabled sources are pending, the lowest vector number is offered.
- R5: A rising edge on an external pin is captured even if the pin is high for a single cycle. The offer appears on the 4th rising clock edge after the pin goes high. A pin held high produces exactly one request.
- R6: Acknowledging an offer drops `vec_valid_o` on the next edge, clears only the served source's pending flag, and blocks every further offer until return-from-interrupt.
- R7: Return-from-interrupt re-opens the global enable. The next eligible pending source is offered on the following edge.
- R8: An offer holds its vector and its valid flag until acknowledged, even if its enable bit is cleared. A newly pending source with a lower vector number replaces the offer. A source with a higher number does not.
- R9: Acknowledge while nothing is offered has no effect. A new request arriving in the same cycle that its own flag is cleared by acknowledge stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_irq_i | input | N_EXT | Asynchronous external interrupt pins |
| per_irq_i | input | N_PER | Synchronous peripheral event strobes |
| irq_en_i | input | N_EXT+N_PER | Per-source enable, bit i for vector i+1 |
| ack_i | input | 1 | Processor accepts the offered vector |
| reti_i | input | 1 | Processor returns from the handler |
| vec_valid_o | output | 1 | A vector is offered |
| vec_addr_o | output | ADDR_W | Word address of the offered vector |
| vec_num_o | output | $clog2(N_EXT+N_PER+1) | Number of the offered vector |

## Verification
The picker is driven with a table of peripheral burst patterns under different enable masks. The bursts include single sources, both ends of the vector range, full bursts and partly masked bursts. These separate a correct lowest-number choice from a highest-number choice, and they show whether a masked source leaks through. Directed sequences cover the rest. Single-cycle and held external pulses show the synchroniser latency and the edge-only capture. Back-to-back acknowledge and return sequences show that only the served flag is cleared and that dispatch stays blocked in between. Late-arriving sources of lower and higher number show that an offer is replaced only by a lower number. Acknowledge in the same cycle as a fresh request shows that the request is not lost.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_pol_e;

endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
   parameter int unsigned           SYNC_STAGES = 2,
   parameter irq_vc_pkg::edge_pol_e POL         = irq_vc_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic evt_o
);
   localparam logic IDLE_LVL = (POL == irq_vc_pkg::EDGE_FALL);

   if (SYNC_STAGES < 2) begin : g_err_sync
      $error("irq_edge_cap: SYNC_STAGES must be at least 2");
   end

   // chain[SYNC_STAGES-1] is the synchronised level, chain[SYNC_STAGES] its delayed copy
   logic [SYNC_STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(SYNC_STAGES+1){IDLE_LVL}};
      else        chain <= {chain[SYNC_STAGES-1:0], pin_i};
   end

   if (POL == irq_vc_pkg::EDGE_RISE) begin : g_rise
      assign evt_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
   end else begin : g_fall
      assign evt_o = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
   end

   // R5: one edge yields one event
   a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o);

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   if (N < 1) begin : g_err_n
      $error("irq_pend_bank: N must be at least 1");
   end

   // a fresh request beats a clear of the same flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_i) | set_i;
   end

   // R6: at most one flag cleared per cycle
   a_r6_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_i));

endmodule

// File: rtl/irq_fixed_pick.sv
module irq_fixed_pick #(
   parameter int unsigned N     = 7,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   if (N < 2) begin : g_err_n
      $error("irq_fixed_pick: N must be at least 2");
   end

   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |req_i;

   // R4: the chosen index is itself requesting
   a_r4_pick_live: assert final (!any_o || req_i[idx_o]);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int unsigned           N_EXT       = 2,
   parameter int unsigned           N_PER       = 4,
   parameter int unsigned           VEC_STRIDE  = 2,
   parameter int unsigned           ADDR_W      = 4,
   parameter int unsigned           SYNC_STAGES = 2,
   parameter irq_vc_pkg::edge_pol_e EXT_POL     = irq_vc_pkg::EDGE_RISE,
   localparam int unsigned          N_SRC       = N_EXT + N_PER,
   localparam int unsigned          N_VEC       = N_SRC + 1,
   localparam int unsigned          IDX_W       = $clog2(N_VEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EXT-1:0]  ext_irq_i,
   input  logic [N_PER-1:0]  per_irq_i,
   input  logic [N_SRC-1:0]  irq_en_i,
   input  logic              ack_i,
   input  logic              reti_i,
   output logic              vec_valid_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic [IDX_W-1:0]  vec_num_o
);
   localparam int unsigned TOP_ADDR = (N_VEC - 1) * VEC_STRIDE;

   if (N_EXT < 1) begin : g_err_ext
      $error("irq_vector_ctrl: N_EXT must be at least 1");
   end
   if (N_PER < 1) begin : g_err_per
      $error("irq_vector_ctrl: N_PER must be at least 1");
   end
   if (VEC_STRIDE < 1) begin : g_err_stride
      $error("irq_vector_ctrl: VEC_STRIDE must be at least 1");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_err_addr
      $error("irq_vector_ctrl: ADDR_W too narrow for the vector table");
   end

   logic [N_EXT-1:0] ext_evt;
   logic [N_SRC-1:0] src_set, src_clr, src_pend;
   logic [N_VEC-1:0] elig;
   logic             pick_any;
   logic [IDX_W-1:0] pick_idx;
   logic             valid_q, ie_q, boot_q;
   logic [IDX_W-1:0] idx_q;
   logic             take;

   // external pins: synchronise then detect edge
   for (genvar k = 0; k < N_EXT; k++) begin : g_ext
      irq_edge_cap #(
         .SYNC_STAGES (SYNC_STAGES),
         .POL         (EXT_POL)
      ) i_cap (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_i (ext_irq_i[k]),
         .evt_o (ext_evt[k])
      );
   end

   assign src_set = {per_irq_i, ext_evt};
   assign take    = ack_i && valid_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_clr
      assign src_clr[i] = take && (idx_q == IDX_W'(i + 1));
   end

   irq_pend_bank #(.N(N_SRC)) i_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_set),
      .clr_i  (src_clr),
      .pend_o (src_pend)
   );

   // vector 0 (boot) ignores mask and global enable
   assign elig = {src_pend & irq_en_i & {N_SRC{ie_q}}, boot_q};

   irq_fixed_pick #(.N(N_VEC), .IDX_W(IDX_W)) i_pick (
      .req_i (elig),
      .any_o (pick_any),
      .idx_o (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b1;
         idx_q   <= '0;
         ie_q    <= 1'b0;
         boot_q  <= 1'b1;
      end else if (take) begin
         valid_q <= 1'b0;
         ie_q    <= (idx_q == '0);
         if (idx_q == '0) boot_q <= 1'b0;
      end else begin
         if (reti_i) ie_q <= 1'b1;
         if (!valid_q) begin
            if (pick_any) begin
               valid_q <= 1'b1;
               idx_q   <= pick_idx;
            end
         end else if (pick_any && (pick_idx < idx_q)) begin
            idx_q <= pick_idx;
         end
      end
   end

   assign vec_valid_o = valid_q;
   assign vec_num_o   = idx_q;
   assign vec_addr_o  = ADDR_W'(32'(idx_q) * VEC_STRIDE);

   // ---------------- assertions ----------------
   logic [N_VEC-1:0] en_full_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_full_d <= '1;
      else        en_full_d <= {irq_en_i, 1'b1};
   end

   a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && !ack_i) |=> vec_valid_o);

   a_r8_no_demote: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && !ack_i) |=> (vec_num_o <= $past(vec_num_o)));

   a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && ack_i) |=> !vec_valid_o);

   a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !boot_q && !vec_valid_o) |=> !vec_valid_o);

   a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(vec_valid_o) && vec_num_o != '0) |-> en_full_d[vec_num_o]);

   a_r1_boot_first: assert property (@(posedge clk) disable iff (!rst_n)
      boot_q |-> (vec_valid_o && vec_num_o == '0));

   for (genvar i = 0; i < N_SRC; i++) begin : g_chk_latch
      a_r5_latch: assert property (@(posedge clk) disable iff (!rst_n)
         src_set[i] |=> src_pend[i]);
   end

endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
   localparam int N_EXT = 2;
   localparam int N_PER = 4;
   localparam int N_SRC = N_EXT + N_PER;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [N_EXT-1:0] ext_irq;
   logic [N_PER-1:0] per_irq;
   logic [N_SRC-1:0] irq_en;
   logic             ack, reti;
   logic             vec_valid;
   logic [3:0]       vec_addr;
   logic [2:0]       vec_num;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_irq_i   (ext_irq),
      .per_irq_i   (per_irq),
      .irq_en_i    (irq_en),
      .ack_i       (ack),
      .reti_i      (reti),
      .vec_valid_o (vec_valid),
      .vec_addr_o  (vec_addr),
      .vec_num_o   (vec_num)
   );

   // {enable[5:0], peripheral burst[3:0], expect valid, expect addr[3:0]}
   localparam logic [14:0] TBL [0:7] = '{
      {6'b111111, 4'b0001, 1'b1, 4'd6},
      {6'b111111, 4'b1000, 1'b1, 4'd12},
      {6'b111111, 4'b1010, 1'b1, 4'd8},
      {6'b111111, 4'b1111, 1'b1, 4'd6},
      {6'b111011, 4'b0011, 1'b1, 4'd8},
      {6'b000000, 4'b1111, 1'b0, 4'd0},
      {6'b100000, 4'b1111, 1'b1, 4'd12},
      {6'b011100, 4'b0110, 1'b1, 4'd8}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input bit ev, input int ea);
      n_chk++;
      if (vec_valid !== ev || (ev && vec_addr !== 4'(ea))) begin
         n_fail++;
         $display("FAIL %s: valid=%0b addr=%0d, expected valid=%0b addr=%0d",
                  req, vec_valid, vec_addr, ev, ea);
      end
   endtask

   task automatic pulse_per(input logic [N_PER-1:0] m);
      per_irq = m;
      tick(1);
      per_irq = '0;
   endtask

   task automatic do_ack();
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      tick(1);
      reti = 1'b0;
   endtask

   task automatic drain();
      irq_en = '1;
      tick(1);
      for (int k = 0; k < 12; k++) begin
         if (vec_valid) begin
            do_ack();
            do_reti();
            tick(1);
         end else break;
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run state=hung, expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ext_irq = '0; per_irq = '0; irq_en = '1; ack = 1'b0; reti = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1 reset vector offered", 1'b1, 0);
      pulse_per(4'b0001);
      tick(1);
      chk("R1 reset vector kept over pending", 1'b1, 0);
      do_ack();
      chk("R6 offer dropped after reset ack", 1'b0, 0);
      tick(1);
      chk("R1 enable opened by reset ack", 1'b1, 6);
      do_ack(); do_reti(); tick(1);
      chk("R7 nothing left", 1'b0, 0);

      // table of bursts: R2 R3 R4
      for (int v = 0; v < 8; v++) begin
         irq_en = TBL[v][14:9];
         pulse_per(TBL[v][8:5]);
         tick(1);
         chk($sformatf("R4 R3 R2 table entry %0d", v), TBL[v][4], int'(TBL[v][3:0]));
         drain();
      end

      // R5: one-cycle pin pulse and latency
      ext_irq[1] = 1'b1; tick(1); ext_irq[1] = 1'b0;
      tick(2);
      chk("R5 not yet offered after 3 edges", 1'b0, 0);
      tick(1);
      chk("R5 R2 short pulse on pin 1", 1'b1, 4);
      do_ack(); do_reti(); tick(1);
      chk("R5 pin 1 served", 1'b0, 0);
      ext_irq[0] = 1'b1;
      tick(4);
      chk("R2 pin 0 address", 1'b1, 2);
      do_ack(); do_reti(); tick(3);
      chk("R5 held level no second request", 1'b0, 0);
      ext_irq[0] = 1'b0;
      tick(3);

      // R6 / R7
      pulse_per(4'b0011); tick(1);
      chk("R6 first of two", 1'b1, 6);
      do_ack();
      chk("R6 dropped after ack", 1'b0, 0);
      tick(4);
      chk("R6 blocked until reti", 1'b0, 0);
      do_reti(); tick(1);
      chk("R7 next offered after reti", 1'b1, 8);
      do_ack(); do_reti(); tick(2);
      chk("R6 served flag cleared", 1'b0, 0);

      // R8
      pulse_per(4'b1000); tick(1);
      chk("R8 initial offer", 1'b1, 12);
      pulse_per(4'b0001); tick(1);
      chk("R8 lower number replaces", 1'b1, 6);
      pulse_per(4'b0100); tick(1);
      chk("R8 higher number does not replace", 1'b1, 6);
      irq_en = '0; tick(3);
      chk("R8 offer held with enable cleared", 1'b1, 6);
      irq_en = '1;
      do_ack(); do_reti(); tick(1);
      chk("R8 R4 next pending", 1'b1, 10);
      do_ack(); do_reti(); tick(1);
      chk("R8 last pending", 1'b1, 12);
      do_ack(); do_reti(); tick(2);
      chk("R8 drained", 1'b0, 0);

      // R3
      irq_en = '0;
      pulse_per(4'b0010); tick(4);
      chk("R3 masked not offered", 1'b0, 0);
      irq_en = '1; tick(1);
      chk("R3 offered once enabled", 1'b1, 8);
      do_ack(); do_reti(); tick(2);
      chk("R3 drained", 1'b0, 0);

      // R9
      do_ack(); tick(1);
      pulse_per(4'b0001); tick(1);
      chk("R9 idle ack ignored", 1'b1, 6);
      per_irq = 4'b0001; ack = 1'b1;
      tick(1);
      per_irq = '0; ack = 1'b0;
      chk("R9 ack drops offer", 1'b0, 0);
      do_reti(); tick(1);
      chk("R9 same-cycle request kept", 1'b1, 6);
      do_ack(); do_reti(); tick(2);
      chk("R9 drained", 1'b0, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule